// File: doc/BRIEF.md
# NMI Aggregator with Acknowledgment Watchdog

This block collects six serious-error indications from across a device into a single non-maskable interrupt for the main processor. Each indication latches a sticky pending flag on its rising edge. The NMI output stays high while any flag is set. The six indications are: clock failure, an external pin request, a vector-fetch error on a secondary core, a timeout reset from the secondary core's own watchdog, a stuck handshake between the processors, and a voltage regulator warning.

Raising the NMI also starts an acknowledgment counter on the main clock. Software acknowledges the interrupt by writing ones to a flag-clear register. The counter returns to zero only when every flag is clear. If it reaches the programmed period first, the block emits a one-cycle device reset pulse and returns all flags and the counter to their reset values. A small register port gives access to a status word, the clear and force registers and the period.

Top module: `nmi_guard`

## Requirements
- R1: A rising edge on `src_in[i]` sets flag i. Bit 0 is clock failure, 1 the external pin request, 2 the secondary vector-fetch error, 3 the secondary watchdog reset, 4 the stuck handshake and 5 the regulator warning. An input that stays high does not set the flag again after the flag is cleared.
- R2: `nmi_out` is high in every cycle in which at least one flag is set, and low when none is set.
- R3: Writing address 1 (clear) with bit i = 1 clears flag i on the next clock edge. Bits written as 0 leave their flags unchanged.
- R4: Reading address 0 (status) returns the flags in bits 5:0 and a summary pending bit in bit 6 that is 1 when any flag is set. All higher bits read as 0.
- R5: When a rising edge on a source and a clear of the same flag arrive in the same cycle, the flag stays set.
- R6: Writing address 2 (force) with bit i = 1 sets flag i on the next clock edge, just as a source edge would.
- R7: Suppose a flag first becomes set at clock edge E0 and is not acknowledged. With period P, `wdog_rst` is then high for exactly one cycle, after edge E(P+1). At that same edge all flags and the counter return to zero.
- R8: If all flags are cleared before the pulse, no reset pulse is produced. The next NMI counts again from zero, so its pulse arrives P+1 edges after the new flag is set.
- R9: With a period of 0, the pulse is produced on the first clock edge after the flag is set.
- R10: Address 3 holds the period, which is readable and writable and resets to `DEF_PERIOD`. The clear and force addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main subsystem clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Error indications, one bit per source |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 clear, 2 force, 3 period |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| nmi_out | output | 1 | Non-maskable interrupt to the interrupt controller |
| wdog_rst | output | 1 | One-cycle device reset request |

## Verification
Two functions can fall on the same edge: a source edge that sets a flag and a software clear of that same flag. The bench provokes this by raising a source in the cycle that carries a clear write for its bit. It judges the outcome through the status read in the following cycle, which must still show the flag and the pending bit. A second collision is a clear that lands too late to stop the counter. The bench avoids that case on purpose and instead checks the exact edge of the pulse for periods of 0 and 5 and after a counter restart.

// File: rtl/nmi_guard_pkg.sv
// Shared register selector encoding for the NMI aggregator.
package nmi_guard_pkg;
    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_CLEAR  = 2'd1,
        REG_FORCE  = 2'd2,
        REG_PERIOD = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/nmi_src_flags.sv
// Sticky pending flags, one per error source.
// Assumes: src_in is synchronous to clk. A wipe request overrides everything else.
// A set (source edge or force) overrides a clear in the same cycle.
module nmi_src_flags #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] force_set,
    input  logic [NUM_SRC-1:0] ack_clr,
    input  logic               wipe,
    output logic [NUM_SRC-1:0] flags
);
    logic [NUM_SRC-1:0] src_prev;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        logic rise;
        assign rise = src_in[i] & ~src_prev[i];

        // Track the previous source level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) src_prev[i] <= 1'b0;
            else        src_prev[i] <= src_in[i];
        end

        // Update one flag: wipe, then set, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                     flags[i] <= 1'b0;
            else if (wipe)                  flags[i] <= 1'b0;
            else if (rise || force_set[i])  flags[i] <= 1'b1;
            else if (ack_clr[i])            flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/nmi_ack_timer.sv
// Acknowledgment watchdog: counts while any flag is pending and fires when
// the count reaches the period.
// Assumes: the period may change at any time. Since the compare is >=, a lowered
// period fires at once and never lets the count wrap.
module nmi_ack_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic [CNT_W-1:0] period,
    output logic             fire_now,
    output logic             rst_pulse
);
    logic [CNT_W-1:0] cnt;

    assign fire_now = pending && (cnt >= period);

    // Advance, hold at zero while idle, restart after firing.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!pending || fire_now) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    // Register the fire decision into a one-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= fire_now;
    end
endmodule

// File: rtl/nmi_reg_port.sv
// Register write/read port: status, write-one-to-clear, write-one-to-set, period.
// Assumes: DATA_W >= CNT_W and DATA_W > NUM_SRC.
module nmi_reg_port
    import nmi_guard_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 16,
    parameter int DEF_PERIOD = 4095
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] flags,
    output logic [DATA_W-1:0]  rdata,
    output logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] set_bits,
    output logic [CNT_W-1:0]   period
);
    localparam logic [CNT_W-1:0] PERIOD_RST = CNT_W'(DEF_PERIOD);

    // Decode write strobes for the clear and force registers.
    always_comb begin
        clr_bits = '0;
        set_bits = '0;
        if (wr_en && addr == REG_CLEAR) clr_bits = wdata[NUM_SRC-1:0];
        if (wr_en && addr == REG_FORCE) set_bits = wdata[NUM_SRC-1:0];
    end

    // Hold the watchdog period.
    always_ff @(posedge clk) begin
        if (!rst_n)                            period <= PERIOD_RST;
        else if (wr_en && addr == REG_PERIOD)  period <= wdata[CNT_W-1:0];
    end

    // Return read data for the selected register.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_STATUS: begin
                rdata[NUM_SRC-1:0] = flags;
                rdata[NUM_SRC]     = |flags;
            end
            REG_PERIOD: rdata[CNT_W-1:0] = period;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/nmi_guard.sv
// Top: NMI aggregator with acknowledgment watchdog.
// Assumes: all inputs synchronous to clk. rst_n is active low and sampled on clk.
module nmi_guard #(
    parameter int NUM_SRC    = 6,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 16,
    parameter int DEF_PERIOD = 4095
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               nmi_out,
    output logic               wdog_rst
);
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] clr_bits;
    logic [NUM_SRC-1:0] set_bits;
    logic [CNT_W-1:0]   period;
    logic               fire_now;

    assign nmi_out = |flags;

    nmi_reg_port #(
        .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_PERIOD(DEF_PERIOD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .flags(flags), .rdata(reg_rdata),
        .clr_bits(clr_bits), .set_bits(set_bits), .period(period)
    );

    nmi_src_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .force_set(set_bits),
        .ack_clr(clr_bits), .wipe(fire_now), .flags(flags)
    );

    nmi_ack_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .pending(nmi_out), .period(period),
        .fire_now(fire_now), .rst_pulse(wdog_rst)
    );
endmodule

// File: rtl/nmi_guard_checker.sv
// Port-level assertions for nmi_guard, attached by bind.
module nmi_guard_checker
    import nmi_guard_pkg::*;
#(
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_in,
    input logic               reg_wr_en,
    input logic [1:0]         reg_addr,
    input logic [NUM_SRC-1:0] clr_bits,
    input logic               status_pend,
    input logic               nmi_out,
    input logic               wdog_rst
);
    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);                                       // R7
    AST_RST_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> !nmi_out);                                        // R7
    AST_RST_NEEDS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> $past(nmi_out));                                  // R7
    AST_STATUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_STATUS) |-> (status_pend == nmi_out));        // R4
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == REG_CLEAR && &clr_bits && src_in == '0)
        |=> !nmi_out);                                                 // R3
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_rise
        AST_RISE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_in[i]) |=> (nmi_out || wdog_rst));               // R1
    end
endmodule

bind nmi_guard nmi_guard_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .clr_bits(reg_wdata[NUM_SRC-1:0]),
    .status_pend(reg_rdata[NUM_SRC]), .nmi_out(nmi_out), .wdog_rst(wdog_rst)
);

// File: tb/test_nmi_guard.sv
// Scoreboard bench: driver tasks queue expectations, a negedge monitor compares.
module test_nmi_guard;
    localparam int DEF_P = 4095;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_in = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        nmi_out;
    logic        wdog_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 nmi_out, 2 wdog_rst
        string       req;
        logic [15:0] exp;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    nmi_guard i_nmi_guard (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nmi_out(nmi_out), .wdog_rst(wdog_rst)
    );

    // Monitor: pop every queued expectation and compare at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {15'd0, nmi_out};
                default: act = {15'd0, wdog_rst};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d: actual %0h expected %0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic push(input int kind, input string req, input logic [15:0] exp);
        item_t it;
        it.kind = kind; it.req = req; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [15:0] exp, input string req);
        reg_addr = a;
        push(0, req, exp);
        sample();
    endtask

    task automatic chk_pins(input logic n, input logic r, input string req);
        push(1, req, {15'd0, n});
        push(2, req, {15'd0, r});
        sample();
    endtask

    task automatic do_write(input logic [1:0] a, input logic [15:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    // Raise a source, then expect P+1 edges of NMI before the pulse (R7/R8).
    task automatic run_to_pulse(input int bitn, input int p, input string req);
        src_in[bitn] = 1'b1;
        tick();
        for (int k = 0; k <= p; k++) begin
            chk_pins(1'b1, 1'b0, req);
            tick();
        end
        chk_pins(1'b0, 1'b1, req);
        tick();
        chk_pins(1'b0, 1'b0, req);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state
        chk_rd(2'd0, 16'h0000, "R4 reset status");
        chk_rd(2'd3, 16'(DEF_P), "R10 reset period");
        chk_pins(1'b0, 1'b0, "R2 reset pins");

        // R7: unacknowledged NMI with period 5
        do_write(2'd3, 16'd5);
        chk_rd(2'd3, 16'd5, "R10 period readback");
        run_to_pulse(0, 5, "R7");
        chk_rd(2'd0, 16'h0000, "R7 flags wiped");
        // R1: input held high does not re-set the flag
        repeat (3) tick();
        chk_pins(1'b0, 1'b0, "R1 held level");
        src_in[0] = 1'b0;
        tick();

        // R9: period zero
        do_write(2'd3, 16'd0);
        src_in[5] = 1'b1;
        tick();
        chk_pins(1'b1, 1'b0, "R9 raised");
        tick();
        chk_pins(1'b0, 1'b1, "R9 pulse");
        src_in[5] = 1'b0;
        tick();
        chk_pins(1'b0, 1'b0, "R9 single");

        // R8: acknowledged in time, then restart from zero
        do_write(2'd3, 16'd5);
        src_in[2] = 1'b1;
        tick(); tick(); tick();
        do_write(2'd1, 16'h0004);
        chk_pins(1'b0, 1'b0, "R8 acknowledged");
        src_in[2] = 1'b0;
        for (int k = 0; k < 10; k++) begin
            tick();
            chk_pins(1'b0, 1'b0, "R8 no pulse");
        end
        run_to_pulse(2, 5, "R8 restart");
        src_in[2] = 1'b0;
        tick();

        // R6 force, R3 partial clear, R5 collision
        do_write(2'd3, 16'd200);
        do_write(2'd2, 16'h0005);
        chk_rd(2'd0, 16'h0045, "R6 force sets");
        chk_rd(2'd2, 16'h0000, "R10 force reads zero");
        chk_rd(2'd1, 16'h0000, "R10 clear reads zero");
        do_write(2'd1, 16'h0001);
        chk_rd(2'd0, 16'h0044, "R3 partial clear");
        src_in[1] = 1'b1;
        do_write(2'd1, 16'h0002);
        chk_rd(2'd0, 16'h0046, "R5 edge beats clear");
        chk_pins(1'b1, 1'b0, "R2 pending");
        do_write(2'd1, 16'h003F);
        chk_rd(2'd0, 16'h0000, "R3 clear all");
        chk_pins(1'b0, 1'b0, "R2 idle");
        src_in[1] = 1'b0;
        tick();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule